// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that finishes every instruction in one clock. It runs a small subset of a classic three-format instruction set: register add and subtract, OR with an immediate, word load, word store, branch on equal and an absolute jump. It holds the program counter, a 32-entry register file, a two-operand ALU with a zero flag, an immediate extender, a fixed control decoder, and two 256-word memories, one for instructions and one for data.

Both memories are filled through a load port, and only while the core is held in reset. After reset is released the core fetches from word 0 and retires one instruction on each rising edge. A combinational debug port reads any register, so a bench can compare the architectural state against its own model.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, the PC reads 0, every register reads 0, and a load with `ld_en` high writes `ld_data` into word `ld_addr` of the instruction memory (`ld_sel`=0) or the data memory (`ld_sel`=1). While `rst_n` is high the load port has no effect.
- R2: Instruction fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0], jump target [25:0]. Opcode 000000 is the register format. Within it, funct 100000 is add and funct 100010 is sub, and both write the result to rd.
- R3: The ALU adds, subtracts (rs minus the second operand) or ORs. Its internal 2-bit select is 00 for add, 01 for subtract and 10 for OR. The zero flag is set when the result is all zeros.
- R4: Opcode 001101 (ori) writes rs OR the zero-extended immediate to rt.
- R5: Opcode 100011 (lw) writes the data word at address rs + sign-extended immediate to rt. Opcode 101011 (sw) writes rt to that address and writes no register.
- R6: Register 0 always reads 0, and writes to it are discarded.
- R7: Opcode 000100 (beq) writes nothing. If rs equals rt, the next PC is PC+4+(sign-extended immediate shifted left by 2); otherwise it is PC+4.
- R8: Opcode 000010 (j) sets the next PC to {PC[31:28], target, 2'b00} and writes nothing.
- R9: Any other opcode, and any other funct under opcode 000000, is a no-op: no register write, no memory write, and the PC advances by 4.
- R10: Every instruction other than a taken beq or a j advances the PC by 4.
- R11: `dbg_data` shows the current value of register `dbg_idx` in the same cycle.
- R12: Each memory holds 256 words selected by address bits [9:2]. Reads are combinational. Writes occur on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; also opens the load port |
| ld_en | input | 1 | Load strobe, used only during reset |
| ld_sel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | 8 | Word index for the load |
| ld_data | input | 32 | Word to load |
| dbg_idx | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Value of the selected register |
| pc_out | output | 32 | Address of the instruction being executed |

## Verification
Each instruction retires in the cycle it is fetched, so a wrong next-PC choice (a missed branch, a misplaced jump target, a step other than 4) shows on `pc_out` at the very next rising edge. The bench compares that value on every cycle. A corrupted register or memory word shows only when the value is read. The debug port exposes it as soon as it is written, while a bad stored word shows when a later load brings it into a register. The program therefore stores and then loads the same word, and the bench reads back every register at the end.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam logic [5:0] OPC_RFMT = 6'b000000;
  localparam logic [5:0] OPC_ORI  = 6'b001101;
  localparam logic [5:0] OPC_LW   = 6'b100011;
  localparam logic [5:0] OPC_SW   = 6'b101011;
  localparam logic [5:0] OPC_BEQ  = 6'b000100;
  localparam logic [5:0] OPC_J    = 6'b000010;
  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic    valid;
    logic    reg_we;
    logic    dst_rd;
    logic    src_imm;
    logic    sign_ext;
    logic    mem_to_reg;
    logic    mem_we;
    logic    is_branch;
    logic    is_jump;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [31:0] extend_imm(input logic [15:0] imm, input logic sgn);
    extend_imm = sgn ? {{16{imm[15]}}, imm} : {16'h0000, imm};
  endfunction

  function automatic logic [31:0] alu_calc(input alu_op_e op, input logic [31:0] a,
                                           input logic [31:0] b);
    case (op)
      ALU_SUB: alu_calc = a - b;
      ALU_OR:  alu_calc = a | b;
      default: alu_calc = a + b;
    endcase
  endfunction

  function automatic logic [31:0] branch_dest(input logic [31:0] pc, input logic [15:0] off);
    branch_dest = pc + 32'd4 + {extend_imm(off, 1'b1)[29:0], 2'b00};
  endfunction

  function automatic logic [31:0] jump_dest(input logic [31:0] pc, input logic [25:0] tgt);
    jump_dest = {pc[31:28], tgt, 2'b00};
  endfunction

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OPC_RFMT: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctrl.valid  = 1'b1;
          ctrl.reg_we = 1'b1;
          ctrl.dst_rd = 1'b1;
          ctrl.alu_op = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
        end
      end
      OPC_ORI: begin
        ctrl.valid   = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.alu_op  = ALU_OR;
      end
      OPC_LW: begin
        ctrl.valid      = 1'b1;
        ctrl.reg_we     = 1'b1;
        ctrl.src_imm    = 1'b1;
        ctrl.sign_ext   = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OPC_SW: begin
        ctrl.valid    = 1'b1;
        ctrl.src_imm  = 1'b1;
        ctrl.sign_ext = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.valid     = 1'b1;
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      OPC_J: begin
        ctrl.valid   = 1'b1;
        ctrl.is_jump = 1'b1;
      end
      default: ctrl = ctrl;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] aidx,
  output logic [W-1:0]  adata,
  input  logic [IW-1:0] bidx,
  output logic [W-1:0]  bdata,
  input  logic [IW-1:0] didx,
  output logic [W-1:0]  ddata
);
  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[g] <= '0;
        else        regs[g] <= '0;
      end
    end else begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          regs[g] <= '0;
        else if (we && widx == IW'(g))       regs[g] <= wdata;
      end
    end
  end

  assign adata = regs[aidx];
  assign bdata = regs[bidx];
  assign ddata = regs[didx];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  assign y    = alu_calc(op, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int DEPTH = 256,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  localparam int AW       = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic          ld_sel,
  input  logic [AW-1:0] ld_addr,
  input  logic [31:0]   ld_data,
  input  logic [4:0]    dbg_idx,
  output logic [31:0]   dbg_data,
  output logic [31:0]   pc_out
);
  logic [31:0] pc_q, pc_next, pc_plus4;
  logic [31:0] instr;
  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd, wr_idx;
  logic [15:0] imm16;
  logic [25:0] jtgt;
  ctrl_t       ctrl;
  logic [31:0] rs_data, rt_data, imm_ext, alu_b, alu_y, mem_rdata, wb_data;
  logic        alu_zero;

  // named events for the checker
  logic reg_we, mem_we, is_branch, is_jump, take_br, ctrl_valid;

  // load port is live only in reset
  logic          imem_we, dmem_we;
  logic [AW-1:0] dmem_waddr;
  logic [31:0]   dmem_wdata;

  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign funct  = instr[5:0];
  assign imm16  = instr[15:0];
  assign jtgt   = instr[25:0];

  sc_decoder u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  assign ctrl_valid = ctrl.valid;
  assign is_branch  = ctrl.is_branch;
  assign is_jump    = ctrl.is_jump;
  assign reg_we     = ctrl.reg_we & rst_n;
  assign mem_we     = ctrl.mem_we & rst_n;
  assign wr_idx     = ctrl.dst_rd ? rd : rt;

  sc_regfile #(.NREG(32), .W(32)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .widx  (wr_idx),
    .wdata (wb_data),
    .aidx  (rs),
    .adata (rs_data),
    .bidx  (rt),
    .bdata (rt_data),
    .didx  (dbg_idx),
    .ddata (dbg_data)
  );

  assign imm_ext = extend_imm(imm16, ctrl.sign_ext);
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_data;

  sc_alu #(.W(32)) u_alu (
    .op   (ctrl.alu_op),
    .a    (rs_data),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign imem_we    = !rst_n && ld_en && !ld_sel;
  assign dmem_we    = rst_n ? mem_we : (ld_en && ld_sel);
  assign dmem_waddr = rst_n ? alu_y[AW+1:2] : ld_addr;
  assign dmem_wdata = rst_n ? rt_data : ld_data;

  sc_mem #(.DEPTH(MEM_WORDS), .W(32)) u_imem (
    .clk   (clk),
    .we    (imem_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (pc_q[AW+1:2]),
    .rdata (instr)
  );

  sc_mem #(.DEPTH(MEM_WORDS), .W(32)) u_dmem (
    .clk   (clk),
    .we    (dmem_we),
    .waddr (dmem_waddr),
    .wdata (dmem_wdata),
    .raddr (alu_y[AW+1:2]),
    .rdata (mem_rdata)
  );

  assign wb_data = ctrl.mem_to_reg ? mem_rdata : alu_y;

  assign take_br  = is_branch & alu_zero;
  assign pc_plus4 = pc_q + 32'd4;

  always_comb begin
    if (is_jump)      pc_next = jump_dest(pc_q, jtgt);
    else if (take_br) pc_next = branch_dest(pc_q, imm16);
    else              pc_next = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

  assign pc_out = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc_q,
  input logic [31:0] instr,
  input logic [31:0] rs_data,
  input logic [31:0] rt_data,
  input logic        alu_zero,
  input logic        reg_we,
  input logic        mem_we,
  input logic        is_branch,
  input logic        is_jump,
  input logic        take_br,
  input logic        ctrl_valid,
  input logic [4:0]  dbg_idx,
  input logic [31:0] dbg_data
);
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00);                                                      // R10

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_br && !is_jump) |=> pc_q == $past(pc_q) + 32'd4);                  // R10

  AST_BRANCH_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    take_br |=> pc_q == $past(pc_q) + 32'd4 +
      {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});                   // R7

  AST_BEQ_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
    is_branch |-> (alu_zero == (rs_data == rt_data)));                        // R7

  AST_JUMP_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    is_jump |=> pc_q == {$past(pc_q[31:28]), $past(instr[25:0]), 2'b00});     // R8

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_valid |-> (!reg_we && !mem_we));                                    // R9

  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !reg_we);                                                      // R5

  AST_REG0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_idx == 5'd0) |-> (dbg_data == 32'd0));                               // R6
endmodule

bind sc_core sc_core_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_q       (pc_q),
  .instr      (instr),
  .rs_data    (rs_data),
  .rt_data    (rt_data),
  .alu_zero   (alu_zero),
  .reg_we     (reg_we),
  .mem_we     (mem_we),
  .is_branch  (is_branch),
  .is_jump    (is_jump),
  .take_br    (take_br),
  .ctrl_valid (ctrl_valid),
  .dbg_idx    (dbg_idx),
  .dbg_data   (dbg_data)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic        ld_sel = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  dbg_idx = '0;
  logic [31:0] dbg_data;
  logic [31:0] pc_out;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];

  // reference model state
  logic [31:0] m_reg [32];
  logic [31:0] m_imem [256];
  logic [31:0] m_dmem [256];
  logic [31:0] m_pc;

  always #5 clk = ~clk;

  sc_core dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .dbg_idx(dbg_idx), .dbg_data(dbg_data), .pc_out(pc_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int s, input int t, input int d,
                                        input logic [5:0] fn);
    enc_r = {6'b000000, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t,
                                        input logic [15:0] imm);
    enc_i = {op, 5'(s), 5'(t), imm};
  endfunction

  // one step of the reference model
  task automatic model_step();
    logic [31:0] ins, a, b, sx, zx, addr;
    ins  = m_imem[m_pc[9:2]];
    a    = m_reg[ins[25:21]];
    b    = m_reg[ins[20:16]];
    sx   = {{16{ins[15]}}, ins[15:0]};
    zx   = {16'h0, ins[15:0]};
    addr = a + sx;
    case (ins[31:26])
      6'b000000: begin
        if (ins[5:0] == 6'b100000)      m_reg[ins[15:11]] = a + b;
        else if (ins[5:0] == 6'b100010) m_reg[ins[15:11]] = a - b;
        m_pc = m_pc + 4;
      end
      6'b001101: begin m_reg[ins[20:16]] = a | zx; m_pc = m_pc + 4; end
      6'b100011: begin m_reg[ins[20:16]] = m_dmem[addr[9:2]]; m_pc = m_pc + 4; end
      6'b101011: begin m_dmem[addr[9:2]] = b; m_pc = m_pc + 4; end
      6'b000100: m_pc = (a == b) ? m_pc + 4 + (sx << 2) : m_pc + 4;
      6'b000010: m_pc = {m_pc[31:28], ins[25:0], 2'b00};
      default:   m_pc = m_pc + 4;
    endcase
    m_reg[0] = '0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on && exp_q.size() > 0) begin
      logic [31:0] e;
      e = exp_q.pop_front();
      check(pc_out == e, "R7 R8 R9 R10 pc sequence", pc_out, e);
    end
  end

  task automatic read_reg(input int idx, output logic [31:0] v);
    dbg_idx = 5'(idx);
    #1 v = dbg_data;
  endtask

  task automatic drive_program();
    for (int i = 0; i < 256; i++) begin m_imem[i] = '0; m_dmem[i] = '0; end
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_imem[0]  = enc_i(6'b001101, 0, 1, 16'h0005);
    m_imem[1]  = enc_i(6'b001101, 0, 2, 16'hFFFF);
    m_imem[2]  = enc_r(1, 2, 3, 6'b100000);
    m_imem[3]  = enc_r(1, 2, 4, 6'b100010);
    m_imem[4]  = enc_i(6'b001101, 0, 5, 16'h0048);
    m_imem[5]  = enc_i(6'b101011, 5, 3, 16'hFFFC);
    m_imem[6]  = enc_i(6'b100011, 5, 6, 16'hFFFC);
    m_imem[7]  = enc_r(1, 1, 0, 6'b100000);
    m_imem[8]  = enc_r(0, 1, 7, 6'b100000);
    m_imem[9]  = enc_i(6'b000100, 1, 2, 16'h0005);
    m_imem[10] = enc_i(6'b000100, 1, 7, 16'h0002);
    m_imem[11] = enc_i(6'b001101, 0, 8, 16'h0BAD);
    m_imem[12] = enc_i(6'b001101, 0, 8, 16'h0BAD);
    m_imem[13] = enc_i(6'b111111, 0, 9, 16'h0033);
    m_imem[14] = enc_r(1, 1, 10, 6'b100101);
    m_imem[15] = {6'b000010, 26'd20};
    for (int i = 16; i < 20; i++) m_imem[i] = enc_i(6'b001101, 0, 8, 16'h0BAD);
    m_imem[20] = enc_i(6'b001101, 0, 11, 16'h1234);
    m_imem[21] = enc_i(6'b100011, 0, 12, 16'h000C);
    m_imem[22] = enc_i(6'b000100, 0, 0, 16'hFFFF);
    m_dmem[3]  = 32'hCAFE_F00D;
    for (int k = 0; k < 512; k++) begin
      @(negedge clk);
      ld_en   = 1'b1;
      ld_sel  = (k >= 256);
      ld_addr = 8'(k % 256);
      ld_data = (k >= 256) ? m_dmem[k % 256] : m_imem[k];
    end
    @(negedge clk);
    ld_en = 1'b0;
    m_pc = '0;
    for (int s = 0; s < 40; s++) begin
      model_step();
      exp_q.push_back(m_pc);
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (2) @(negedge clk);
    drive_program();
    check(pc_out == 32'd0, "R1 pc held at 0 in reset", pc_out, 32'd0);
    read_reg(1, v);
    check(v == 32'd0, "R1 register cleared in reset", v, 32'd0);
    @(negedge clk);
    #1 rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (41) @(negedge clk);
    mon_on = 1'b0;
    #2;
    read_reg(2, v);  check(v == 32'h0000_FFFF, "R4 ori zero-extends", v, 32'h0000_FFFF);
    read_reg(3, v);  check(v == 32'h0001_0004, "R2 R3 add to rd", v, 32'h0001_0004);
    read_reg(4, v);  check(v == 32'hFFFF_0006, "R2 R3 sub to rd", v, 32'hFFFF_0006);
    read_reg(6, v);  check(v == 32'h0001_0004, "R5 sw then lw same word", v, 32'h0001_0004);
    read_reg(0, v);  check(v == 32'd0, "R6 reg0 write discarded", v, 32'd0);
    read_reg(7, v);  check(v == 32'd5, "R6 reg0 reads zero as operand", v, 32'd5);
    read_reg(8, v);  check(v == 32'd0, "R7 taken beq skips words", v, 32'd0);
    read_reg(9, v);  check(v == 32'd0, "R9 unknown opcode no write", v, 32'd0);
    read_reg(10, v); check(v == 32'd0, "R9 unknown funct no write", v, 32'd0);
    read_reg(11, v); check(v == 32'h1234, "R8 jump lands on target", v, 32'h1234);
    read_reg(12, v); check(v == 32'hCAFE_F00D, "R12 preloaded data word", v, 32'hCAFE_F00D);
    read_reg(1, v);  check(v == 32'd5, "R11 debug read", v, 32'd5);
    for (int r = 0; r < 32; r++) begin
      read_reg(r, v);
      check(v == m_reg[r], "R2 register file vs model", v, m_reg[r]);
    end
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 1'b0; ld_addr = 8'd22;
    ld_data = enc_i(6'b001101, 0, 13, 16'h0077);
    @(negedge clk);
    ld_en = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    read_reg(13, v);
    check(v == 32'd0, "R1 load ignored while running", v, 32'd0);
    check(pc_out == 32'd88, "R1 R7 halt loop unchanged", pc_out, 32'd88);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule